// File: doc/BRIEF.md
# L2 Reload Return Sequencer

This block stands on the memory side of a core-to-L2 reload path. It takes instruction-fetch, load, reserve-load and inter-thread transfer requests, each with a tag, a real address, a length code and a cache-inhibit bit. It answers them in arrival order with 128-bit data beats read from a small built-in word store. Every beat is announced ahead of time. A "coming" strobe may lead the beat by three cycles. A "valid" strobe, together with the tag, quadword index, critical flag and inter-thread flag, leads it by two cycles.

A mode input chooses the return pattern. In consecutive mode the beats of a transaction come on adjacent cycles. In alternate mode they come on every other cycle. The coming strobe obeys pair rules that depend on the mode and on whether the request is cacheable. Requests with a bad length code or a bad type raise a one-cycle error flag and are dropped.

Top module: `l2_reload_sequencer`

## Requirements
- R1: `rld_valid` is high exactly two cycles before each data beat and for no other cycle. In that cycle `rld_tag`, `rld_qw`, `rld_crit` and `rld_itc` describe the beat. While `rld_valid` is low, `rld_tag` is 5'h1F and the other three are 0.
- R2: In consecutive mode (`b2b_mode`=1), a 4-beat cacheable reload returns its beats on four adjacent cycles. `rld_coming` pulses three cycles before beat 0 and three cycles before beat 2, and at no other time.
- R3: In alternate mode (`b2b_mode`=0), beats come two cycles apart and `rld_coming` stays low for cacheable reloads.
- R4: A cache-inhibited reload pulses `rld_coming` once, three cycles before its first beat, in either mode. Such a reload has two beats only when the type is fetch (8'h00) or load (8'h08) and the length code is 7. Every other inhibited reload has one beat.
- R5: A cacheable reload returns the four 16-byte quadwords of its 64-byte-aligned line, with `rld_qw` counting 0 to 3. `rld_crit` is high on the beat whose index equals request address bits [5:4]. An inhibited reload flags its first beat as critical.
- R6: Type 8'h22 (inter-thread transfer) always returns four beats of the aligned line, with `rld_itc` high alongside `rld_valid`, and never raises `rld_coming`.
- R7: A request with length code 0 or 3, or with a type other than 8'h00, 8'h08, 8'h09, 8'h0B or 8'h22, raises `req_err` in the next cycle and produces no beats.
- R8: An inhibited beat's address is the request address with bits [3:0] cleared, plus 16 for the second beat. The beat data for byte address A is the four words with indices w=A/4 .. A/4+3, first word in bits [127:96]. Word w is {w[15:0], ~w[15:0]}.
- R9: A request that finds the block idle gets its first beat six cycles after the request cycle. A later request starts its first beat two cycles after the last beat of the one before it. Up to `DEPTH` requests may wait.
- R10: `ld_pop` pulses for one cycle together with the final data beat of each transaction.
- R11: After reset every strobe is low, `rld_data` is zero and `rld_tag` is 5'h1F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| b2b_mode | input | 1 | 1 = consecutive-cycle returns, 0 = every other cycle |
| req_valid | input | 1 | Request present this cycle |
| req_type | input | 8 | Request type code |
| req_tag | input | 5 | Request tag |
| req_addr | input | 32 | Real byte address |
| req_len | input | 3 | Length code |
| req_inhibit | input | 1 | Cache-inhibited request |
| req_err | output | 1 | Dropped illegal request (one cycle later) |
| rld_coming | output | 1 | Early announce, three cycles before a beat |
| rld_valid | output | 1 | Beat qualifier, two cycles before a beat |
| rld_tag | output | 5 | Tag of the announced beat |
| rld_qw | output | 2 | Quadword index of the announced beat |
| rld_crit | output | 1 | Announced beat is the critical quadword |
| rld_itc | output | 1 | Announced beat belongs to an inter-thread transfer |
| rld_data | output | 128 | Beat data, zero outside beats |
| ld_pop | output | 1 | Final beat of a transaction |

## Verification
The bench covers every critical-quadword position in both modes. A design that derives the flag from the wrong address bits, or that reorders beats, shows up as a wrong `rld_crit` or `rld_qw`. Inhibited fetches with length code 7 are set against reserve loads with the same code: a decoder that ignores the type returns two beats for a reserve load. Inter-thread transfers check that `rld_coming` stays quiet even in consecutive mode. Three requests issued back to back check the two-cycle gap between transactions: a sequencer that starts a new transaction too early collides with the earlier strobes, and one that starts too late shifts every later beat. Illegal codes are followed by a legal request in the same run, so a dropped request that leaks into the queue would show up as extra beats.

// File: rtl/reload_pkg.sv
// Shared widths, request type codes, transaction and beat records, and the
// built-in word store pattern. Assumes byte addresses and 32-bit words.
package reload_pkg;
    localparam int TAG_W  = 5;
    localparam int ADDR_W = 32;

    localparam logic [7:0] TY_FETCH = 8'h00;
    localparam logic [7:0] TY_LOAD  = 8'h08;
    localparam logic [7:0] TY_RSV   = 8'h09;
    localparam logic [7:0] TY_RSVH  = 8'h0B;
    localparam logic [7:0] TY_ITC   = 8'h22;

    // Decoded request waiting in the queue or being returned
    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] base;
        logic [2:0]        nbeats;
        logic [1:0]        crit;
        logic              inh;
        logic              itc;
    } txn_t;

    // One planned beat travelling down the strobe pipe
    typedef struct packed {
        logic              v;
        logic              coming;
        logic              last;
        logic              itc;
        logic              crit;
        logic [1:0]        qw;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] addr;
    } beat_t;

    // Content of the word store at word index wi
    function automatic logic [31:0] mem_word(input logic [15:0] wi);
        return {wi, ~wi};
    endfunction
endpackage

// File: rtl/reload_req_queue.sv
// In-order request queue of decoded transactions.
// Assumes the requester never pushes into a full queue.
module reload_req_queue
    import reload_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push_i,
    input  txn_t push_data_i,
    input  logic pop_i,
    output txn_t head_o,
    output logic avail_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    txn_t          slots [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          full;

    assign full    = (count == CW'(DEPTH));
    assign avail_o = (count != '0);
    assign head_o  = slots[rd_ptr];

    // Write the incoming transaction into the slot at the write pointer
    always_ff @(posedge clk) begin
        if (push_i) slots[wr_ptr] <= push_data_i;
    end

    // Advance the pointers and the occupancy count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_i) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_i)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(push_i) - CW'(pop_i);
        end
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push_i);
    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> avail_o);
endmodule

// File: rtl/reload_beat_planner.sv
// Takes one transaction at a time and decides, cycle by cycle, whether a beat
// is planned for four cycles later, together with its coming flag.
// Assumes b2b_i is held steady while a transaction is being returned.
module reload_beat_planner
    import reload_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  b2b_i,
    input  txn_t  head_i,
    input  logic  head_avail_i,
    output logic  take_o,
    output beat_t plan_o
);
    txn_t       cur;
    logic       active;
    logic       phase;
    logic [2:0] idx;
    logic       fire;
    logic       last;

    assign fire   = active && (b2b_i || !phase);
    assign last   = (idx == cur.nbeats - 3'd1);
    assign take_o = !active && head_avail_i;

    // Track the active transaction, its beat index and the alternate phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cur    <= '0;
            idx    <= '0;
            phase  <= 1'b0;
        end else if (take_o) begin
            active <= 1'b1;
            cur    <= head_i;
            idx    <= '0;
            phase  <= 1'b0;
        end else if (active) begin
            phase <= ~phase;
            if (fire) begin
                idx <= idx + 3'd1;
                if (last) active <= 1'b0;
            end
        end
    end

    // Build the planned beat record, applying the pair rules for coming
    always_comb begin
        plan_o        = '0;
        plan_o.v      = fire;
        plan_o.last   = fire && last;
        plan_o.qw     = idx[1:0];
        plan_o.crit   = (idx[1:0] == cur.crit);
        plan_o.itc    = cur.itc;
        plan_o.tag    = cur.tag;
        plan_o.addr   = cur.base + (ADDR_W'(idx) << 4);
        plan_o.coming = fire && !cur.itc &&
                        (cur.inh ? (idx == 3'd0) : (b2b_i && !idx[0]));
    end

    assert_alt_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!b2b_i && fire) |=> !fire);
    assert_beat_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (idx < cur.nbeats));
endmodule

// File: rtl/reload_strobe_pipe.sv
// Delays each planned beat so the coming strobe leads the data by three
// cycles and valid with its fields leads it by two; forms data and pop.
// Assumes the planner emits at most one beat per cycle.
module reload_strobe_pipe
    import reload_pkg::*;
#(
    parameter int LEAD_COMING = 3,
    parameter int LEAD_VALID  = 2,
    parameter int BEAT_W      = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  beat_t             plan_i,
    output logic              coming_o,
    output logic              valid_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic [1:0]        qw_o,
    output logic              crit_o,
    output logic              itc_o,
    output logic [BEAT_W-1:0] data_o,
    output logic              pop_o
);
    localparam int NSTG  = LEAD_COMING + 1;
    localparam int WORDS = BEAT_W / 32;

    beat_t             stg [NSTG];
    logic [ADDR_W-1:0] widx;

    // Shift planned beats toward the data stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NSTG; k++) stg[k] <= '0;
        end else begin
            stg[NSTG-1] <= plan_i;
            for (int k = 0; k < NSTG - 1; k++) stg[k] <= stg[k+1];
        end
    end

    assign coming_o = stg[LEAD_COMING].v && stg[LEAD_COMING].coming;
    assign valid_o  = stg[LEAD_VALID].v;
    assign tag_o    = stg[LEAD_VALID].v ? stg[LEAD_VALID].tag : '1;
    assign qw_o     = stg[LEAD_VALID].v ? stg[LEAD_VALID].qw : 2'd0;
    assign crit_o   = stg[LEAD_VALID].v && stg[LEAD_VALID].crit;
    assign itc_o    = stg[LEAD_VALID].v && stg[LEAD_VALID].itc;
    assign pop_o    = stg[0].v && stg[0].last;
    assign widx     = stg[0].addr >> 2;

    for (genvar j = 0; j < WORDS; j++) begin : g_word
        logic [ADDR_W-1:0] wj;
        assign wj = widx + ADDR_W'(j);
        assign data_o[BEAT_W-1-32*j -: 32] = stg[0].v ? mem_word(wj[15:0]) : 32'd0;
    end

    assert_coming_then_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        coming_o |=> valid_o);
    assert_pop_after_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pop_o |-> $past(valid_o, 2));
endmodule

// File: rtl/l2_reload_sequencer.sv
// Top of the reload return sequencer: decodes and checks requests, queues
// them, plans beats in order and drives the staggered reload strobes.
// Assumes b2b_mode changes only while no transaction is outstanding.
module l2_reload_sequencer
    import reload_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int BEAT_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              b2b_mode,
    input  logic              req_valid,
    input  logic [7:0]        req_type,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_len,
    input  logic              req_inhibit,
    output logic              req_err,
    output logic              rld_coming,
    output logic              rld_valid,
    output logic [TAG_W-1:0]  rld_tag,
    output logic [1:0]        rld_qw,
    output logic              rld_crit,
    output logic              rld_itc,
    output logic [BEAT_W-1:0] rld_data,
    output logic              ld_pop
);
    logic  type_ok, len_ok, is_itc, is_line, push;
    txn_t  dec, head;
    logic  avail, take;
    beat_t plan;

    // Check the request and decode it into a transaction record
    always_comb begin
        type_ok = (req_type == TY_FETCH) || (req_type == TY_LOAD) ||
                  (req_type == TY_RSV)   || (req_type == TY_RSVH) ||
                  (req_type == TY_ITC);
        len_ok  = (req_len != 3'd0) && (req_len != 3'd3);
        is_itc  = (req_type == TY_ITC);
        is_line = is_itc || !req_inhibit;
        push    = req_valid && type_ok && len_ok;

        dec      = '0;
        dec.tag  = req_tag;
        dec.itc  = is_itc;
        dec.inh  = !is_line;
        dec.crit = is_line ? req_addr[5:4] : 2'd0;
        dec.base = is_line ? {req_addr[ADDR_W-1:6], 6'd0} : {req_addr[ADDR_W-1:4], 4'd0};
        if (is_line)
            dec.nbeats = 3'd4;
        else if (((req_type == TY_FETCH) || (req_type == TY_LOAD)) && (req_len == 3'd7))
            dec.nbeats = 3'd2;
        else
            dec.nbeats = 3'd1;
    end

    // Flag a dropped illegal request one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) req_err <= 1'b0;
        else        req_err <= req_valid && !(type_ok && len_ok);
    end

    reload_req_queue #(.DEPTH(DEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n), .push_i(push), .push_data_i(dec),
        .pop_i(take), .head_o(head), .avail_o(avail)
    );

    reload_beat_planner u_planner (
        .clk(clk), .rst_n(rst_n), .b2b_i(b2b_mode), .head_i(head),
        .head_avail_i(avail), .take_o(take), .plan_o(plan)
    );

    reload_strobe_pipe #(.LEAD_COMING(3), .LEAD_VALID(2), .BEAT_W(BEAT_W)) u_pipe (
        .clk(clk), .rst_n(rst_n), .plan_i(plan), .coming_o(rld_coming),
        .valid_o(rld_valid), .tag_o(rld_tag), .qw_o(rld_qw), .crit_o(rld_crit),
        .itc_o(rld_itc), .data_o(rld_data), .pop_o(ld_pop)
    );

    assert_err_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> $past(req_valid));
    assert_itc_qualified_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rld_itc |-> rld_valid);
    assert_coming_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rld_coming && !b2b_mode) |=> !rld_coming);
endmodule

// File: tb/l2_reload_sequencer_bench.sv
module l2_reload_sequencer_bench;
    localparam int WIN = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         b2b_mode = 1'b0;
    logic         req_valid = 1'b0;
    logic [7:0]   req_type = 8'h0;
    logic [4:0]   req_tag = 5'h0;
    logic [31:0]  req_addr = 32'h0;
    logic [2:0]   req_len = 3'h0;
    logic         req_inhibit = 1'b0;
    logic         req_err, rld_coming, rld_valid, rld_crit, rld_itc, ld_pop;
    logic [4:0]   rld_tag;
    logic [1:0]   rld_qw;
    logic [127:0] rld_data;

    always #5 clk = ~clk;

    l2_reload_sequencer u_l2_reload_sequencer (
        .clk(clk), .rst_n(rst_n), .b2b_mode(b2b_mode), .req_valid(req_valid),
        .req_type(req_type), .req_tag(req_tag), .req_addr(req_addr),
        .req_len(req_len), .req_inhibit(req_inhibit), .req_err(req_err),
        .rld_coming(rld_coming), .rld_valid(rld_valid), .rld_tag(rld_tag),
        .rld_qw(rld_qw), .rld_crit(rld_crit), .rld_itc(rld_itc),
        .rld_data(rld_data), .ld_pop(ld_pop)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // expected per-cycle outputs within one scenario window
    logic         e_com [WIN];
    logic         e_val [WIN];
    logic [4:0]   e_tag [WIN];
    logic [1:0]   e_qw  [WIN];
    logic         e_crit[WIN];
    logic         e_itc [WIN];
    logic [127:0] e_dat [WIN];
    logic         e_pop [WIN];
    logic         e_err [WIN];

    // pending stimulus
    int          q_n;
    int          q_t [4];
    logic [7:0]  q_ty[4];
    logic [4:0]  q_tg[4];
    logic [31:0] q_a [4];
    logic [2:0]  q_l [4];
    logic        q_i [4];
    int          last_d;

    task automatic check(input bit ok, input string rq, input int t,
                         input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s t=%0d actual=%h expected=%h", rq, t, act, exp);
        end
    endtask

    function automatic logic [127:0] beat_data(input logic [31:0] a);
        logic [127:0] d;
        logic [31:0] w;
        w = a >> 2;
        for (int j = 0; j < 4; j++) begin
            logic [31:0] wj;
            wj = w + 32'(j);
            d[127-32*j -: 32] = {wj[15:0], ~wj[15:0]};
        end
        return d;
    endfunction

    task automatic clear_scn();
        for (int t = 0; t < WIN; t++) begin
            e_com[t] = 0; e_val[t] = 0; e_tag[t] = 5'h1F; e_qw[t] = 0;
            e_crit[t] = 0; e_itc[t] = 0; e_dat[t] = '0; e_pop[t] = 0; e_err[t] = 0;
        end
        q_n = 0;
        last_d = -100;
    endtask

    // Record a request and compute its expected strobes from the requirements
    task automatic add_req(input int r, input logic [7:0] ty, input logic [4:0] tg,
                           input logic [31:0] a, input logic [2:0] ln, input logic inh);
        bit ok_t, ok_l, itc, line;
        int nb, cr, start, step;
        logic [31:0] base;
        q_t[q_n] = r; q_ty[q_n] = ty; q_tg[q_n] = tg; q_a[q_n] = a;
        q_l[q_n] = ln; q_i[q_n] = inh; q_n++;
        ok_t = ty inside {8'h00, 8'h08, 8'h09, 8'h0B, 8'h22};
        ok_l = (ln != 3'd0) && (ln != 3'd3);
        if (!(ok_t && ok_l)) begin
            e_err[r+1] = 1;                       // R7
            return;
        end
        itc  = (ty == 8'h22);
        line = itc || !inh;
        if (line) nb = 4;
        else if ((ty == 8'h00 || ty == 8'h08) && ln == 3'd7) nb = 2;   // R4
        else nb = 1;
        base  = line ? {a[31:6], 6'd0} : {a[31:4], 4'd0};              // R8
        cr    = line ? int'(a[5:4]) : 0;                               // R5
        start = (r + 6 > last_d + 2) ? r + 6 : last_d + 2;             // R9
        step  = b2b_mode ? 1 : 2;
        for (int k = 0; k < nb; k++) begin
            int d;
            d = start + k * step;
            e_val[d-2]  = 1;
            e_tag[d-2]  = tg;
            e_qw[d-2]   = 2'(k);
            e_crit[d-2] = (k == cr);
            e_itc[d-2]  = itc;
            e_dat[d]    = beat_data(base + 32'(16 * k));
            if (k == nb - 1) e_pop[d] = 1;                             // R10
            if (!itc && (line ? (b2b_mode && (k % 2 == 0)) : (k == 0)))
                e_com[d-3] = 1;                                        // R2 R3 R4 R6
        end
        last_d = start + (nb - 1) * step;
    endtask

    // Drive the window and compare every output every cycle
    task automatic run_scn(input string crq);
        for (int t = 0; t < WIN; t++) begin
            #1;
            req_valid = 0;
            for (int i = 0; i < q_n; i++) begin
                if (q_t[i] == t) begin
                    req_valid = 1; req_type = q_ty[i]; req_tag = q_tg[i];
                    req_addr = q_a[i]; req_len = q_l[i]; req_inhibit = q_i[i];
                end
            end
            @(negedge clk);
            check(rld_coming == e_com[t], crq, t, 128'(rld_coming), 128'(e_com[t]));
            check(rld_valid == e_val[t], "R1", t, 128'(rld_valid), 128'(e_val[t]));
            check(rld_tag == e_tag[t], "R1", t, 128'(rld_tag), 128'(e_tag[t]));
            check(rld_qw == e_qw[t], "R5", t, 128'(rld_qw), 128'(e_qw[t]));
            check(rld_crit == e_crit[t], "R5", t, 128'(rld_crit), 128'(e_crit[t]));
            check(rld_itc == e_itc[t], "R6", t, 128'(rld_itc), 128'(e_itc[t]));
            check(rld_data == e_dat[t], "R8", t, rld_data, e_dat[t]);
            check(ld_pop == e_pop[t], "R10", t, 128'(ld_pop), 128'(e_pop[t]));
            check(req_err == e_err[t], "R7", t, 128'(req_err), 128'(e_err[t]));
            @(posedge clk);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R11: idle outputs after reset
        check({rld_coming, rld_valid, rld_crit, rld_itc, ld_pop, req_err} == 6'b0,
              "R11", 0, 128'({rld_coming, rld_valid, rld_crit, rld_itc, ld_pop}), 128'(0));
        check(rld_tag == 5'h1F && rld_qw == 2'd0, "R11", 0, 128'({rld_tag, rld_qw}), 128'({5'h1F, 2'd0}));
        check(rld_data == '0, "R11", 0, rld_data, '0);
        @(posedge clk);

        for (int m = 0; m < 2; m++) begin
            b2b_mode = m[0];
            // R5 with R2/R3: every critical quadword position, cacheable load and fetch
            for (int s = 0; s < 4; s++) begin
                clear_scn();
                add_req(0, (s % 2) ? 8'h08 : 8'h00, 5'(s + 4 * m),
                        32'h0000_1000 + 32'(16 * s) + 32'd4, 3'd6, 1'b0);
                run_scn(m ? "R2" : "R3");
            end
            // R6: inter-thread transfer, also with inhibit set
            for (int i = 0; i < 2; i++) begin
                clear_scn();
                add_req(0, 8'h22, 5'd9, 32'h0000_2030, 3'd7, i[0]);
                run_scn("R6");
            end
            // R4: inhibited reloads of one and two beats
            clear_scn(); add_req(0, 8'h00, 5'd3, 32'h0000_3018, 3'd7, 1'b1); run_scn("R4");
            clear_scn(); add_req(0, 8'h08, 5'd4, 32'h0000_3024, 3'd7, 1'b1); run_scn("R4");
            clear_scn(); add_req(0, 8'h08, 5'd5, 32'h0000_3048, 3'd5, 1'b1); run_scn("R4");
            clear_scn(); add_req(0, 8'h09, 5'd6, 32'h0000_3050, 3'd7, 1'b1); run_scn("R4");
            clear_scn(); add_req(0, 8'h0B, 5'd7, 32'h0000_307C, 3'd6, 1'b1); run_scn("R4");
            // R7: illegal codes dropped, followed by a legal request
            clear_scn();
            add_req(0, 8'h08, 5'd1, 32'h0000_4000, 3'd0, 1'b0);
            add_req(1, 8'h08, 5'd2, 32'h0000_4010, 3'd3, 1'b1);
            add_req(2, 8'h20, 5'd3, 32'h0000_4020, 3'd6, 1'b0);
            add_req(3, 8'h00, 5'd4, 32'h0000_4030, 3'd6, 1'b1);
            run_scn("R7");
            // R9: three requests queued behind each other
            clear_scn();
            add_req(0, 8'h08, 5'd10, 32'h0000_5020, 3'd6, 1'b0);
            add_req(1, 8'h00, 5'd11, 32'h0000_5104, 3'd7, 1'b1);
            add_req(2, 8'h22, 5'd12, 32'h0000_5210, 3'd7, 1'b0);
            run_scn("R9");
            // R9: a request arriving while a transaction is finishing
            clear_scn();
            add_req(0, 8'h09, 5'd13, 32'h0000_6000, 3'd7, 1'b1);
            add_req(3, 8'h08, 5'd14, 32'h0000_6040, 3'd7, 1'b1);
            run_scn("R9");
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule